// File: doc/BRIEF.md
# Reloading Down-Counter Tick Timer

This block generates a periodic tick for a processor subsystem. A down-counter runs from a programmable reload value to zero and then loads the reload value again, so one full period is reload plus one counting steps. Each pass from 1 to 0 sets a sticky status flag and, when enabled, raises an interrupt request. The flag is cleared by reading the control/status word, so software samples and acknowledges it in a single access.

Three word registers sit on a simple single-cycle register bus. Read data is presented combinationally in the cycle of the access. Side effects of an access (flag clear, counter clear, register update) take place at the clock edge that ends it. The counter either steps on every clock or only on clocks where an external reference-enable input is high.

Top module: `tick_timer`

## Requirements
- R1: After reset the control/status word, the reload register and the current count all read as zero, and `irq` is low.
- R2: With enable set and clock source 1 (core clock), the count drops by one per clock. From zero the next step loads the reload value, so the count repeats with period reload+1.
- R3: With clock source 0, the counter steps only on clocks where `ref_tick` is high.
- R4: With enable clear the count holds its value.
- R5: Every step from 1 to 0 sets a sticky wrap flag, seen at bit 16 of the control/status word (word offset 0x0).
- R6: A read of the control/status word returns the flag as it stood before the access and clears it at the end of the access.
- R7: When a wrap and a control/status read fall in the same cycle, the flag is left set.
- R8: A write of any value to the current-count register (offset 0x8) sets the count to zero and clears the flag. The next step then loads the reload value.
- R9: With interrupt enable (control bit 1) set, `irq` is high for exactly the one cycle in which the count first shows zero after a wrap. With it clear, `irq` stays low.
- R10: A write to the reload register (offset 0x4) leaves the running count untouched and is used at the next reload.
- R11: With a reload value of zero the count stays at zero and no wrap, flag or interrupt occurs.
- R12: Reload and current count are CNT_W bits wide. Wider write data is truncated and upper read bits are zero. The control bits enable (bit 0), interrupt enable (bit 1) and source (bit 2) read back as written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; bits 3:2 select the word |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the access cycle |
| ref_tick | input | 1 | External reference step enable |
| irq | output | 1 | One-cycle interrupt request |

## Verification
Two events can land on the same edge: the counter's pass from 1 to 0 and a read of the control/status word, which would both set and clear the flag. The bench computes from the reload value the exact cycle of a wrap and holds a status read across that edge. It expects the pre-access value (clear) during the read and a set flag afterwards. A second read one cycle later must then find the flag cleared.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_IE_BIT   = 1;
    localparam int CTRL_SRC_BIT  = 2;
    localparam int CTRL_FLAG_BIT = 16;

    typedef enum logic [1:0] {
        REG_CTRL   = 2'd0,
        REG_RELOAD = 2'd1,
        REG_CUR    = 2'd2,
        REG_NONE   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic src;
        logic ie;
        logic en;
    } ctrl_t;

endpackage

// File: rtl/tt_bus_decode.sv
module tt_bus_decode
    import tick_timer_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          acc_sel,
    output logic              ctrl_wr,
    output logic              reload_wr,
    output logic              cur_wr,
    output logic              ctrl_rd
);

    logic       hit;
    logic [1:0] word;
    logic       unused_lsb;

    assign word       = addr[3:2];
    assign unused_lsb = ^addr[1:0];

    generate
        if (ADDR_W > 4) begin : g_wide
            assign hit = sel && (addr[ADDR_W-1:4] == '0);
        end else begin : g_narrow
            assign hit = sel;
        end
    endgenerate

    always_comb begin
        acc_sel = REG_NONE;
        if (hit) begin
            case (word)
                2'd0:    acc_sel = REG_CTRL;
                2'd1:    acc_sel = REG_RELOAD;
                2'd2:    acc_sel = REG_CUR;
                default: acc_sel = REG_NONE;
            endcase
        end
        ctrl_wr   = wr  && (acc_sel == REG_CTRL);
        reload_wr = wr  && (acc_sel == REG_RELOAD);
        cur_wr    = wr  && (acc_sel == REG_CUR);
        ctrl_rd   = !wr && (acc_sel == REG_CTRL);
    end

endmodule

// File: rtl/tt_cfg_regs.sv
module tt_cfg_regs
    import tick_timer_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr,
    input  logic             reload_wr,
    input  logic [CNT_W-1:0] wdata,
    output ctrl_t            ctrl,
    output logic [CNT_W-1:0] reload_q
);

    typedef struct packed {
        ctrl_t            ctrl;
        logic [CNT_W-1:0] reload;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (ctrl_wr) begin
            cfg_d.ctrl.en  = wdata[CTRL_EN_BIT];
            cfg_d.ctrl.ie  = wdata[CTRL_IE_BIT];
            cfg_d.ctrl.src = wdata[CTRL_SRC_BIT];
        end
        if (reload_wr) begin
            cfg_d.reload = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign ctrl     = cfg_q.ctrl;
    assign reload_q = cfg_q.reload;

endmodule

// File: rtl/tt_down_counter.sv
module tt_down_counter #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             src_core,
    input  logic             ref_tick,
    input  logic             clear,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] cnt_q,
    output logic             step,
    output logic             wrap
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        step = en && (src_core || ref_tick);
        wrap = 1'b0;
        if (clear) begin
            st_d.cnt = '0;
        end else if (step) begin
            if (st_q.cnt == '0) begin
                st_d.cnt = reload;
            end else begin
                st_d.cnt = st_q.cnt - ONE;
                wrap     = (st_q.cnt == ONE);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_q = st_q.cnt;

endmodule

// File: rtl/tt_wrap_status.sv
module tt_wrap_status (
    input  logic clk,
    input  logic rst_n,
    input  logic wrap,
    input  logic ie,
    input  logic ack_rd,
    input  logic clear,
    output logic flag_q,
    output logic irq_q
);

    typedef struct packed {
        logic flag;
        logic irq;
    } stat_t;

    stat_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ack_rd || clear) begin
            st_d.flag = 1'b0;
        end
        if (wrap) begin
            st_d.flag = 1'b1;
        end
        st_d.irq = wrap && ie;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_q = st_q.flag;
    assign irq_q  = st_q.irq;

endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tick_timer_pkg::*;
#(
    parameter int CNT_W  = 24,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ref_tick,
    output logic              irq
);

    reg_sel_e         acc_sel;
    logic             ctrl_wr;
    logic             reload_wr;
    logic             cur_wr;
    logic             ctrl_rd;
    ctrl_t            ctrl;
    logic [CNT_W-1:0] reload_q;
    logic [CNT_W-1:0] cnt_q;
    logic             step;
    logic             wrap;
    logic             flag_q;

    generate
        if (DATA_W > CNT_W) begin : g_pad
            logic unused_wdata;
            assign unused_wdata = ^bus_wdata[DATA_W-1:CNT_W];
        end
    endgenerate

    tt_bus_decode #(
        .ADDR_W(ADDR_W)
    ) u_decode (
        .sel      (bus_sel),
        .wr       (bus_wr),
        .addr     (bus_addr),
        .acc_sel  (acc_sel),
        .ctrl_wr  (ctrl_wr),
        .reload_wr(reload_wr),
        .cur_wr   (cur_wr),
        .ctrl_rd  (ctrl_rd)
    );

    tt_cfg_regs #(
        .CNT_W(CNT_W)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_wr  (ctrl_wr),
        .reload_wr(reload_wr),
        .wdata    (bus_wdata[CNT_W-1:0]),
        .ctrl     (ctrl),
        .reload_q (reload_q)
    );

    tt_down_counter #(
        .CNT_W(CNT_W)
    ) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (ctrl.en),
        .src_core(ctrl.src),
        .ref_tick(ref_tick),
        .clear   (cur_wr),
        .reload  (reload_q),
        .cnt_q   (cnt_q),
        .step    (step),
        .wrap    (wrap)
    );

    tt_wrap_status u_status (
        .clk   (clk),
        .rst_n (rst_n),
        .wrap  (wrap),
        .ie    (ctrl.ie),
        .ack_rd(ctrl_rd),
        .clear (cur_wr),
        .flag_q(flag_q),
        .irq_q (irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (!bus_wr) begin
            case (acc_sel)
                REG_CTRL: begin
                    bus_rdata[CTRL_EN_BIT]   = ctrl.en;
                    bus_rdata[CTRL_IE_BIT]   = ctrl.ie;
                    bus_rdata[CTRL_SRC_BIT]  = ctrl.src;
                    bus_rdata[CTRL_FLAG_BIT] = flag_q;
                end
                REG_RELOAD: bus_rdata = DATA_W'(reload_q);
                REG_CUR:    bus_rdata = DATA_W'(cnt_q);
                default:    bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
    parameter int CNT_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] reload_q,
    input logic             step,
    input logic             wrap,
    input logic             cur_wr,
    input logic             ctrl_rd,
    input logic             flag_q,
    input logic             irq
);

    // R9
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R9
    irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag_q);

    // R8
    cur_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur_wr |=> (cnt_q == '0) && !flag_q);

    // R6
    rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rd && !wrap) |=> !flag_q);

    // R7
    rd_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rd && wrap) |=> flag_q);

    // R10
    reload_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !cur_wr && cnt_q == '0) |=> cnt_q == $past(reload_q));

    // R2
    count_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !cur_wr && cnt_q != '0) |=> cnt_q == CNT_W'($past(cnt_q) - 1'b1));

    // R4
    freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !cur_wr) |=> $stable(cnt_q));

    // R11
    zero_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reload_q == '0 && cnt_q == '0) |-> !wrap);

endmodule

bind tick_timer tick_timer_chk #(
    .CNT_W(CNT_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cnt_q   (cnt_q),
    .reload_q(reload_q),
    .step    (step),
    .wrap    (wrap),
    .cur_wr  (cur_wr),
    .ctrl_rd (ctrl_rd),
    .flag_q  (flag_q),
    .irq     (irq)
);

// File: tb/tick_timer_bench.sv
module tick_timer_bench;

    localparam int CNT_W  = 8;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 32;
    localparam logic [ADDR_W-1:0] A_CTRL = 4'h0;
    localparam logic [ADDR_W-1:0] A_RLD  = 4'h4;
    localparam logic [ADDR_W-1:0] A_CUR  = 4'h8;
    localparam logic [31:0] FLAG = 32'h0001_0000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_sel = 1'b0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              ref_tick = 1'b0;
    logic              irq;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    tick_timer #(
        .CNT_W (CNT_W),
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_tick_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .ref_tick (ref_tick),
        .irq      (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // called at a negedge; the access takes effect at the next posedge
    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    function automatic int expect_cnt(input int r, input int n);
        if (n == 0) return 0;
        return r - ((n - 1) % (r + 1));
    endfunction

    task automatic summary;
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        chk("R1 irq", {31'b0, irq}, 32'h0);
        rd(A_CTRL, v); chk("R1 ctrl", v, 32'h0);
        rd(A_RLD, v);  chk("R1 reload", v, 32'h0);
        rd(A_CUR, v);  chk("R1 current", v, 32'h0);

        // R12 truncation and control readback
        wr(A_RLD, 32'hFFFF_FFFF);
        rd(A_RLD, v); chk("R12 reload width", v, 32'h0000_00FF);
        wr(A_CUR, 32'h0);
        wr(A_CTRL, 32'hFFFF_FFF8);
        rd(A_CTRL, v); chk("R12 ctrl reserved", v, 32'h0);
        wr(A_CTRL, 32'h0000_0007);
        rd(A_CTRL, v); chk("R12 ctrl readback", v, 32'h0000_0007);
        wr(A_CTRL, 32'h0);
        rd(A_CUR, v); chk("R12 current width", v & 32'hFFFF_FF00, 32'h0);

        // R2 R5 R9 R11 period sweep over reload 0..7
        for (int r = 0; r < 8; r++) begin
            int n_cyc;
            logic ie;
            n_cyc = 3 * (r + 1) + 2;
            ie = r[0];
            wr(A_CTRL, 32'h0);
            wr(A_RLD, r);
            wr(A_CUR, 32'h0);
            wr(A_CTRL, {29'b0, 1'b1, ie, 1'b1});
            bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = A_CUR;
            for (int i = 0; i <= n_cyc; i++) begin
                #1;
                chk(r == 0 ? "R11 count" : "R2 count", bus_rdata, expect_cnt(r, i));
                chk("R9 irq", {31'b0, irq},
                    {31'b0, ie && r > 0 && i > 0 && (i % (r + 1)) == 0});
                @(negedge clk);
            end
            bus_sel = 1'b0;
            wr(A_CTRL, 32'h0);
            rd(A_CTRL, v); chk("R5 flag set", v, (r > 0) ? FLAG : 32'h0);
            rd(A_CTRL, v); chk("R6 flag cleared", v, 32'h0);
        end

        // R3 reference-tick stepping
        begin
            int s;
            s = 0;
            wr(A_RLD, 4);
            wr(A_CUR, 32'h0);
            wr(A_CTRL, 32'h1);
            bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = A_CUR;
            for (int i = 0; i < 24; i++) begin
                #1 chk("R3 ref count", bus_rdata, expect_cnt(4, s));
                ref_tick = (i % 3) != 1;
                @(negedge clk);
                if (ref_tick) s++;
            end
            ref_tick = 1'b0;
            bus_sel = 1'b0;
            wr(A_CTRL, 32'h0);
        end

        // R4 freeze
        wr(A_RLD, 9);
        wr(A_CUR, 32'h0);
        wr(A_CTRL, 32'h5);
        repeat (4) @(negedge clk);
        wr(A_CTRL, 32'h4);
        rd(A_CUR, v); chk("R4 frozen", v, 32'd5);
        repeat (5) @(negedge clk);
        rd(A_CUR, v); chk("R4 still frozen", v, 32'd5);

        // R7 wrap and control read on the same edge
        wr(A_RLD, 3);
        wr(A_CUR, 32'h0);
        wr(A_CTRL, 32'h7);
        repeat (3) @(negedge clk);
        rd(A_CTRL, v); chk("R7 read before wrap", v, 32'h7);
        chk("R9 irq at wrap", {31'b0, irq}, 32'h1);
        rd(A_CTRL, v); chk("R7 flag kept", v, FLAG | 32'h7);
        chk("R9 irq one cycle", {31'b0, irq}, 32'h0);
        rd(A_CTRL, v); chk("R6 flag cleared after R7", v, 32'h7);

        // R8 current write clears count and flag
        wr(A_RLD, 2);
        wr(A_CUR, 32'h0);
        repeat (4) @(negedge clk);
        wr(A_CUR, 32'hABCD_1234);
        rd(A_CUR, v); chk("R8 count zero", v, 32'h0);
        rd(A_CUR, v); chk("R8 reload after clear", v, 32'd2);
        rd(A_CTRL, v); chk("R8 flag cleared", v, 32'h7);

        // R10 reload write does not disturb count
        wr(A_CTRL, 32'h0);
        wr(A_RLD, 5);
        wr(A_CUR, 32'h0);
        wr(A_CTRL, 32'h5);
        wr(A_RLD, 2);
        for (int k = 0; k < 5; k++) begin
            rd(A_CUR, v); chk("R10 old period", v, 5 - k);
        end
        rd(A_CUR, v); chk("R10 zero", v, 32'd0);
        rd(A_CUR, v); chk("R10 new reload", v, 32'd2);
        wr(A_CTRL, 32'h0);

        summary();
        $finish;
    end

endmodule